// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit Load-Store Core

This block is the integer execute step of a simple 32-bit load-store processor. Each cycle it accepts one fixed-width instruction word together with the values already read for its two source registers. It decodes the register-register and register-immediate forms of the arithmetic, logical, compare, shift and upper-immediate operations, and computes the result. It also picks the destination register index and decides whether the register write may go ahead. Everything is combinational up to one output register, so the outcome of an instruction shows one clock after it is presented.

The stage rejects operations it does not know and flags signed overflow on the trapping add and subtract forms. In both cases the register write is withheld, so the surrounding pipeline can raise an exception without corrupting state. The register file, memory access, branches and multiply/divide are handled elsewhere.

Top module: `int_exec_stage`

## Requirements
- R1: Field positions are fixed. opcode = instr[31:26], first source index = instr[25:21] (value on `src_a`), second source index = instr[20:16] (value on `src_b`), shift amount = instr[10:6], function = instr[5:0], immediate = instr[15:0]. The destination is instr[15:11] when opcode is 0 (register form) and instr[20:16] otherwise.
- R2: Register-form functions 0x20 add, 0x21 addu, 0x22 sub and 0x23 subu produce `src_a + src_b` or `src_a - src_b`, modulo 2^32.
- R3: add (0x20), sub (0x22) and the immediate add with opcode 0x08 set `res_ovf` on two's-complement overflow and withhold the write. addu, subu and the immediate add with opcode 0x09 never set `res_ovf`.
- R4: Register-form functions 0x24 and, 0x25 or, 0x26 xor and 0x27 nor produce the bitwise result of `src_a` and `src_b`.
- R5: Immediate opcodes 0x0C and, 0x0D or and 0x0E xor zero-extend the 16-bit immediate. Opcodes 0x08, 0x09, 0x0A and 0x0B sign-extend it. The immediate replaces `src_b`.
- R6: The compares give 1 or 0. Function 0x2A is a signed less-than and 0x2B an unsigned less-than of `src_a` against `src_b`. Opcode 0x0A compares signed and opcode 0x0B compares unsigned, each against the sign-extended immediate.
- R7: Functions 0x00 (left, zero fill), 0x02 (right, zero fill) and 0x03 (right, sign fill) shift `src_b` by instr[10:6].
- R8: Functions 0x04, 0x06 and 0x07 perform the same three shifts using `src_a[4:0]` as the amount, ignoring the upper bits of `src_a`.
- R9: Opcode 0x0F places the immediate in result bits [31:16] and zeros in bits [15:0].
- R10: `res_we` is never set when the destination index is 0.
- R11: Any other opcode, or any other function under opcode 0, sets `res_illegal`, clears `res_we`, and gives `res_data` = 0 and `res_dst` = 0.
- R12: Outputs are registered with one cycle of latency. Reset clears them all, and a cycle with `in_valid` low yields all outputs 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the first source register |
| src_b | input | 32 | Value of the second source register |
| res_valid | output | 1 | Registered copy of in_valid |
| res_data | output | 32 | Result value |
| res_dst | output | 5 | Destination register index |
| res_we | output | 1 | Register write permitted |
| res_ovf | output | 1 | Signed overflow on a trapping operation |
| res_illegal | output | 1 | Unknown operation |

## Verification
The stage keeps no state beyond its output register, so a wrong decode or a wrong operand choice shows on `res_data`, `res_dst` or the flags exactly one clock after the instruction. The bench therefore compares every output on every cycle. It aims stimulus at the edges: operands that overflow by one, immediates with bit 15 set, shift amounts of 0 and 31, and register shift amounts carrying junk in their upper bits. A stale or misdirected write enable is visible at once, because it must drop whenever the destination is register 0, the operation overflows, or the operation is unknown.

// File: rtl/exu_pkg.sv
package exu_pkg;

   localparam int unsigned REG_IDX_W = 5;

   typedef enum logic [3:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
      ALU_SLT, ALU_SLTU, ALU_SHL, ALU_SHR, ALU_SAR, ALU_LUI
   } alu_op_e;

   typedef struct packed {
      alu_op_e              op;
      logic                 use_imm;
      logic                 imm_zext;
      logic                 sh_var;
      logic                 ovf_chk;
      logic [REG_IDX_W-1:0] dst;
      logic                 legal;
   } dec_t;

   // primary opcodes
   localparam logic [5:0] OPC_REG   = 6'h00;
   localparam logic [5:0] OPC_ADDI  = 6'h08;
   localparam logic [5:0] OPC_ADDIU = 6'h09;
   localparam logic [5:0] OPC_SLTI  = 6'h0A;
   localparam logic [5:0] OPC_SLTIU = 6'h0B;
   localparam logic [5:0] OPC_ANDI  = 6'h0C;
   localparam logic [5:0] OPC_ORI   = 6'h0D;
   localparam logic [5:0] OPC_XORI  = 6'h0E;
   localparam logic [5:0] OPC_LUI   = 6'h0F;

   // register-form function codes
   localparam logic [5:0] FN_SLL  = 6'h00;
   localparam logic [5:0] FN_SRL  = 6'h02;
   localparam logic [5:0] FN_SRA  = 6'h03;
   localparam logic [5:0] FN_SLLV = 6'h04;
   localparam logic [5:0] FN_SRLV = 6'h06;
   localparam logic [5:0] FN_SRAV = 6'h07;
   localparam logic [5:0] FN_ADD  = 6'h20;
   localparam logic [5:0] FN_ADDU = 6'h21;
   localparam logic [5:0] FN_SUB  = 6'h22;
   localparam logic [5:0] FN_SUBU = 6'h23;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_XOR  = 6'h26;
   localparam logic [5:0] FN_NOR  = 6'h27;
   localparam logic [5:0] FN_SLT  = 6'h2A;
   localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
   import exu_pkg::*;
#(
   parameter int unsigned INSTR_W = 32
) (
   input  logic [INSTR_W-1:0] instr,
   output dec_t               dec
);

   localparam int unsigned OPC_LSB = INSTR_W - 6;

   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = instr[INSTR_W-1:OPC_LSB];
   assign fn  = instr[5:0];

   always_comb begin
      dec       = '0;
      dec.op    = ALU_ADD;
      dec.legal = 1'b1;
      dec.dst   = instr[20:16];
      case (opc)
         OPC_REG: begin
            dec.dst = instr[15:11];
            case (fn)
               FN_SLL:  dec.op = ALU_SHL;
               FN_SRL:  dec.op = ALU_SHR;
               FN_SRA:  dec.op = ALU_SAR;
               FN_SLLV: begin dec.op = ALU_SHL; dec.sh_var = 1'b1; end
               FN_SRLV: begin dec.op = ALU_SHR; dec.sh_var = 1'b1; end
               FN_SRAV: begin dec.op = ALU_SAR; dec.sh_var = 1'b1; end
               FN_ADD:  begin dec.op = ALU_ADD; dec.ovf_chk = 1'b1; end
               FN_ADDU: dec.op = ALU_ADD;
               FN_SUB:  begin dec.op = ALU_SUB; dec.ovf_chk = 1'b1; end
               FN_SUBU: dec.op = ALU_SUB;
               FN_AND:  dec.op = ALU_AND;
               FN_OR:   dec.op = ALU_OR;
               FN_XOR:  dec.op = ALU_XOR;
               FN_NOR:  dec.op = ALU_NOR;
               FN_SLT:  dec.op = ALU_SLT;
               FN_SLTU: dec.op = ALU_SLTU;
               default: dec.legal = 1'b0;
            endcase
         end
         OPC_ADDI:  begin dec.op = ALU_ADD;  dec.use_imm = 1'b1; dec.ovf_chk = 1'b1; end
         OPC_ADDIU: begin dec.op = ALU_ADD;  dec.use_imm = 1'b1; end
         OPC_SLTI:  begin dec.op = ALU_SLT;  dec.use_imm = 1'b1; end
         OPC_SLTIU: begin dec.op = ALU_SLTU; dec.use_imm = 1'b1; end
         OPC_ANDI:  begin dec.op = ALU_AND;  dec.use_imm = 1'b1; dec.imm_zext = 1'b1; end
         OPC_ORI:   begin dec.op = ALU_OR;   dec.use_imm = 1'b1; dec.imm_zext = 1'b1; end
         OPC_XORI:  begin dec.op = ALU_XOR;  dec.use_imm = 1'b1; dec.imm_zext = 1'b1; end
         OPC_LUI:   begin dec.op = ALU_LUI;  dec.use_imm = 1'b1; end
         default:   dec.legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
   parameter int unsigned W    = 32,
   parameter int unsigned SH_W = $clog2(W)
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   input  logic            left,
   input  logic            arith,
   output logic [W-1:0]    dout
);

   logic [W-1:0] rev_in;
   logic [W-1:0] rev_out;
   logic [W-1:0] stg [0:SH_W];
   logic         fill;

   assign fill = arith & ~left & din[W-1];

   // left shifts run through the right shifter on bit-reversed data
   for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev_in[i]  = din[W-1-i];
      assign rev_out[i] = stg[SH_W][W-1-i];
   end

   assign stg[0] = left ? rev_in : din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int unsigned D = 1 << s;
      assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
   end

   assign dout = left ? rev_out : stg[SH_W];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16
) (
   input  dec_t                    dec,
   input  logic [XLEN-1:0]         opa,
   input  logic [XLEN-1:0]         opb,
   input  logic [IMM_W-1:0]        imm,
   input  logic [$clog2(XLEN)-1:0] shamt,
   output logic [XLEN-1:0]         result,
   output logic                    ovf
);

   localparam int unsigned SH_W = $clog2(XLEN);
   localparam int unsigned MSB  = XLEN - 1;

   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] b;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] diff;
   logic [XLEN-1:0] shifted;
   logic [SH_W-1:0] amt;
   logic            add_ovf;
   logic            sub_ovf;

   assign imm_ext = dec.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm}
                                 : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
   assign b    = dec.use_imm ? imm_ext : opb;
   assign sum  = opa + b;
   assign diff = opa - b;

   assign add_ovf = (opa[MSB] == b[MSB]) && (sum[MSB]  != opa[MSB]);
   assign sub_ovf = (opa[MSB] != b[MSB]) && (diff[MSB] != opa[MSB]);

   assign amt = dec.sh_var ? opa[SH_W-1:0] : shamt;

   exu_shift #(.W(XLEN), .SH_W(SH_W)) u_shift (
      .din   (opb),
      .amt   (amt),
      .left  (dec.op == ALU_SHL),
      .arith (dec.op == ALU_SAR),
      .dout  (shifted)
   );

   always_comb begin
      case (dec.op)
         ALU_ADD:  result = sum;
         ALU_SUB:  result = diff;
         ALU_AND:  result = opa & b;
         ALU_OR:   result = opa | b;
         ALU_XOR:  result = opa ^ b;
         ALU_NOR:  result = ~(opa | b);
         ALU_SLT:  result = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(b))};
         ALU_SLTU: result = {{(XLEN-1){1'b0}}, (opa < b)};
         ALU_SHL, ALU_SHR, ALU_SAR: result = shifted;
         ALU_LUI:  result = {imm, {(XLEN-IMM_W){1'b0}}};
         default:  result = '0;
      endcase
   end

   always_comb begin
      ovf = 1'b0;
      if (dec.ovf_chk) begin
         if (dec.op == ALU_ADD) ovf = add_ovf;
         else if (dec.op == ALU_SUB) ovf = sub_ovf;
      end
   end

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
   import exu_pkg::*;
#(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned IMM_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [XLEN-1:0]      instr,
   input  logic [XLEN-1:0]      src_a,
   input  logic [XLEN-1:0]      src_b,
   output logic                 res_valid,
   output logic [XLEN-1:0]      res_data,
   output logic [REG_IDX_W-1:0] res_dst,
   output logic                 res_we,
   output logic                 res_ovf,
   output logic                 res_illegal
);

   localparam int unsigned SH_W = $clog2(XLEN);

   initial begin
      if (XLEN != 32 || IMM_W != 16)
         $fatal(1, "int_exec_stage: encoding needs XLEN=32 and IMM_W=16");
   end

   dec_t            dec;
   logic [XLEN-1:0] alu_res;
   logic            alu_ovf;
   logic            wr_ok;

   exu_decode #(.INSTR_W(XLEN)) u_dec (
      .instr (instr),
      .dec   (dec)
   );

   exu_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
      .dec    (dec),
      .opa    (src_a),
      .opb    (src_b),
      .imm    (instr[IMM_W-1:0]),
      .shamt  (instr[6+SH_W-1:6]),
      .result (alu_res),
      .ovf    (alu_ovf)
   );

   assign wr_ok = dec.legal && !alu_ovf && (dec.dst != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_dst     <= '0;
         res_we      <= 1'b0;
         res_ovf     <= 1'b0;
         res_illegal <= 1'b0;
      end else begin
         res_valid   <= in_valid;
         res_data    <= (in_valid && dec.legal) ? alu_res : '0;
         res_dst     <= (in_valid && dec.legal) ? dec.dst : '0;
         res_we      <= in_valid && wr_ok;
         res_ovf     <= in_valid && dec.legal && alu_ovf;
         res_illegal <= in_valid && !dec.legal;
      end
   end

endmodule

// File: rtl/int_exec_stage_chk.sv
module int_exec_stage_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] instr,
   input logic        res_valid,
   input logic [31:0] res_data,
   input logic [4:0]  res_dst,
   input logic        res_we,
   input logic        res_ovf,
   input logic        res_illegal
);

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_valid && !res_we && !res_ovf && !res_illegal));

   a_r12_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (res_we || res_ovf || res_illegal) |-> res_valid);

   a_r10_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> (res_dst != 5'd0));

   a_r3_no_write_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      res_ovf |-> !res_we);

   a_r3_unsigned_add_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[31:26] == 6'h09) |=> !res_ovf);

   a_r11_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> (!res_we && res_data == 32'd0 && !res_ovf));

   a_r9_upper_imm: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[31:26] == 6'h0F) |=> (res_data == {$past(instr[15:0]), 16'h0000}));

endmodule

bind int_exec_stage int_exec_stage_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .instr       (instr),
   .res_valid   (res_valid),
   .res_data    (res_data),
   .res_dst     (res_dst),
   .res_we      (res_we),
   .res_ovf     (res_ovf),
   .res_illegal (res_illegal)
);

// File: tb/sim_int_exec_stage.sv
`timescale 1ns/1ps
module sim_int_exec_stage;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic [4:0]  res_dst;
   logic        res_we;
   logic        res_ovf;
   logic        res_illegal;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   int_exec_stage u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
      .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data),
      .res_dst(res_dst), .res_we(res_we), .res_ovf(res_ovf), .res_illegal(res_illegal)
   );

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
   endfunction

   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   function automatic bit s_ovf(longint v);
      return (v > 64'sd2147483647) || (v < -64'sd2147483648);
   endfunction

   // behavioural reference: returns {valid,data,dst,we,ovf,ill}
   function automatic logic [40:0] ref_model(logic vld, logic [31:0] ins,
                                              logic [31:0] a, logic [31:0] b);
      int          op  = int'(ins[31:26]);
      int          fn  = int'(ins[5:0]);
      int          sh  = int'(ins[10:6]);
      int          va  = int'(a[4:0]);
      logic [31:0] se  = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] ze  = {16'h0, ins[15:0]};
      logic [31:0] d   = '0;
      logic [4:0]  dst = (op == 0) ? ins[15:11] : ins[20:16];
      bit          ill = 0;
      bit          ov  = 0;
      longint      sa  = longint'($signed(a));
      if (!vld) return '0;
      if (op == 0) begin
         case (fn)
            'h00: d = b << sh;
            'h02: d = b >> sh;
            'h03: d = $unsigned($signed(b) >>> sh);
            'h04: d = b << va;
            'h06: d = b >> va;
            'h07: d = $unsigned($signed(b) >>> va);
            'h20: begin d = a + b; ov = s_ovf(sa + longint'($signed(b))); end
            'h21: d = a + b;
            'h22: begin d = a - b; ov = s_ovf(sa - longint'($signed(b))); end
            'h23: d = a - b;
            'h24: d = a & b;
            'h25: d = a | b;
            'h26: d = a ^ b;
            'h27: d = ~(a | b);
            'h2A: d = (sa < longint'($signed(b))) ? 1 : 0;
            'h2B: d = (a < b) ? 1 : 0;
            default: ill = 1;
         endcase
      end else begin
         case (op)
            'h08: begin d = a + se; ov = s_ovf(sa + longint'($signed(se))); end
            'h09: d = a + se;
            'h0A: d = (sa < longint'($signed(se))) ? 1 : 0;
            'h0B: d = (a < se) ? 1 : 0;
            'h0C: d = a & ze;
            'h0D: d = a | ze;
            'h0E: d = a ^ ze;
            'h0F: d = ins[15:0] * 32'h10000;
            default: ill = 1;
         endcase
      end
      if (ill) return {1'b1, 32'h0, 5'h0, 1'b0, 1'b0, 1'b1};
      return {1'b1, d, dst, (!ov && dst != 0), ov, 1'b0};
   endfunction

   task automatic check_now(string tag, logic [40:0] exp);
      logic [40:0] got = {res_valid, res_data, res_dst, res_we, res_ovf, res_illegal};
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got v=%b d=%h dst=%0d we=%b ovf=%b ill=%b exp v=%b d=%h dst=%0d we=%b ovf=%b ill=%b",
                  tag, got[40], got[39:8], got[7:3], got[2], got[1], got[0],
                  exp[40], exp[39:8], exp[7:3], exp[2], exp[1], exp[0]);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge (one register)
   task automatic run(string tag, logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
      logic [40:0] exp = ref_model(v, ins, a, b);
      in_valid = v; instr = ins; src_a = a; src_b = b;
      @(negedge clk);
      check_now(tag, exp);
   endtask

   task automatic expect_field(string tag, logic [31:0] d, logic we, logic ovf);
      n_tests++;
      if (res_data !== d || res_we !== we || res_ovf !== ovf) begin
         n_fail++;
         $display("FAIL %s: got d=%h we=%b ovf=%b exp d=%h we=%b ovf=%b",
                  tag, res_data, res_we, res_ovf, d, we, ovf);
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_now("R12 reset state", '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R2: add of rs=3, rt=4 into rd=2
      run("R1 R2 add field layout", 1, 32'h00641020, 32'd5, 32'd7);
      expect_field("R2 add literal", 32'd12, 1'b1, 1'b0);
      run("R2 subu wrap", 1, enc_r(1, 2, 9, 0, 'h23), 32'd3, 32'd5);
      expect_field("R2 subu literal", 32'hFFFF_FFFE, 1'b1, 1'b0);
      // R3 overflow cases
      run("R3 addu no ovf", 1, enc_r(1, 2, 3, 0, 'h21), 32'h7FFF_FFFF, 32'd1);
      run("R3 add ovf", 1, enc_r(1, 2, 3, 0, 'h20), 32'h7FFF_FFFF, 32'd1);
      expect_field("R3 add ovf literal", 32'h8000_0000, 1'b0, 1'b1);
      run("R3 sub ovf", 1, enc_r(1, 2, 3, 0, 'h22), 32'h8000_0000, 32'd1);
      run("R3 addi ovf", 1, enc_i('h08, 1, 4, 'h0001), 32'h7FFF_FFFF, 32'd0);
      run("R3 addiu no ovf", 1, enc_i('h09, 1, 4, 'h0001), 32'h7FFF_FFFF, 32'd0);
      // R4 logic
      run("R4 and", 1, enc_r(1, 2, 5, 0, 'h24), 32'hF0F0_1234, 32'h0FF0_FF00);
      run("R4 or",  1, enc_r(1, 2, 5, 0, 'h25), 32'hF0F0_1234, 32'h0FF0_FF00);
      run("R4 xor", 1, enc_r(1, 2, 5, 0, 'h26), 32'hF0F0_1234, 32'h0FF0_FF00);
      run("R4 nor", 1, enc_r(1, 2, 5, 0, 'h27), 32'hF0F0_1234, 32'h0FF0_FF00);
      expect_field("R4 nor literal", 32'h000F_00CB, 1'b1, 1'b0);
      // R5 immediate extension
      run("R5 andi zext", 1, enc_i('h0C, 1, 6, 'h8001), 32'hFFFF_FFFF, 32'd0);
      expect_field("R5 andi literal", 32'h0000_8001, 1'b1, 1'b0);
      run("R5 addi sext", 1, enc_i('h08, 1, 6, 'hFFFC), 32'd10, 32'd0);
      expect_field("R5 addi literal", 32'd6, 1'b1, 1'b0);
      run("R5 xori zext", 1, enc_i('h0E, 1, 6, 'hFFFF), 32'h1234_5678, 32'd0);
      // R6 compares
      run("R6 slt signed", 1, enc_r(1, 2, 7, 0, 'h2A), 32'hFFFF_FFFF, 32'd1);
      expect_field("R6 slt literal", 32'd1, 1'b1, 1'b0);
      run("R6 sltu unsigned", 1, enc_r(1, 2, 7, 0, 'h2B), 32'hFFFF_FFFF, 32'd1);
      expect_field("R6 sltu literal", 32'd0, 1'b1, 1'b0);
      run("R6 sltiu sext imm", 1, enc_i('h0B, 1, 7, 'hFFFF), 32'd5, 32'd0);
      expect_field("R6 sltiu literal", 32'd1, 1'b1, 1'b0);
      run("R6 slti", 1, enc_i('h0A, 1, 7, 'hFFFF), 32'd5, 32'd0);
      // R7 fixed shifts
      run("R7 sra sign fill", 1, enc_r(0, 2, 8, 2, 'h03), 32'd0, 32'hFFFF_FFF5);
      expect_field("R7 sra literal", 32'hFFFF_FFFD, 1'b1, 1'b0);
      run("R7 srl", 1, enc_r(0, 2, 8, 31, 'h02), 32'd0, 32'h8000_0000);
      run("R7 sll 31", 1, enc_r(0, 2, 8, 31, 'h00), 32'd0, 32'h0000_0003);
      run("R7 sll 0", 1, enc_r(0, 2, 8, 0, 'h00), 32'd0, 32'hDEAD_BEEF);
      // R8 variable shifts use low five bits only
      run("R8 srav low bits", 1, enc_r(1, 2, 8, 9, 'h07), 32'hFFFF_FFE3, 32'h8000_0000);
      expect_field("R8 srav literal", 32'hF000_0000, 1'b1, 1'b0);
      run("R8 sllv", 1, enc_r(1, 2, 8, 0, 'h04), 32'h0000_0024, 32'h0000_0001);
      run("R8 srlv", 1, enc_r(1, 2, 8, 0, 'h06), 32'h0000_001F, 32'hFFFF_FFFF);
      // R9 upper immediate
      run("R9 lui", 1, enc_i('h0F, 3, 9, 'h1234), 32'hFFFF_FFFF, 32'd0);
      expect_field("R9 lui literal", 32'h1234_0000, 1'b1, 1'b0);
      // R10 destination 0
      run("R10 rd zero", 1, enc_r(1, 2, 0, 0, 'h20), 32'd1, 32'd2);
      run("R10 rt zero", 1, enc_i('h0D, 1, 0, 'h00FF), 32'd1, 32'd0);
      // R11 unknown operations
      run("R11 bad opcode", 1, enc_i('h3F, 1, 2, 'h1234), 32'd1, 32'd2);
      run("R11 bad function", 1, enc_r(1, 2, 3, 0, 'h01), 32'd1, 32'd2);
      // R12 idle cycle
      run("R12 idle", 0, enc_r(1, 2, 3, 0, 'h20), 32'd1, 32'd2);

      // mixed stream, compared every clock
      for (int k = 0; k < 600; k++) begin
         int          sel = int'($urandom_range(0, 9));
         logic [31:0] ins;
         logic [31:0] a = $urandom;
         logic [31:0] b = $urandom;
         int          fns [16] = '{'h00, 'h02, 'h03, 'h04, 'h06, 'h07, 'h20, 'h21,
                                   'h22, 'h23, 'h24, 'h25, 'h26, 'h27, 'h2A, 'h2B};
         if (sel < 4)
            ins = enc_r(int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                        int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                        fns[$urandom_range(0, 15)]);
         else if (sel < 8)
            ins = enc_i(int'($urandom_range(8, 15)), int'($urandom_range(0, 31)),
                        int'($urandom_range(0, 31)), int'($urandom));
         else
            ins = $urandom;
         if (k % 7 == 0) begin a = 32'h7FFF_FFFF; b = 32'h0000_0001; end
         if (k % 11 == 0) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
         run("R2 R3 R5 R6 R7 R8 mixed", (k % 13) != 0, ins, a, b);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule